// File: doc/BRIEF.md
# Coil-Driver Register Target on a Two-Wire Serial Bus

This block is the register side of a lens-focus coil driver. It listens on an I2C bus as a target at the fixed 7-bit address 0001110. It keeps an 8-bit register pointer and a small register file. That file holds a control byte, a 10-bit coil current split over two bytes, a read-only fault byte, a mode byte and a resonance-frequency byte. The current is staged: the high byte can be written first, and the full 10-bit value reaches the output, with a one-cycle commit pulse, only when the low byte is written. The pointer survives from one transaction to the next and steps after every byte transferred, so one address phase can be followed by a run of writes or reads.

The bus lines are oversampled by the system clock. Both lines pass through a two-stage synchronizer, and edges, START and STOP are found on the synchronized levels. A protocol state machine with the states IDLE, ADDR, ADDR_ACK, PTR, PTR_ACK, WDATA, WDATA_ACK, TX and TX_ACK steers the bytes. The transitions are:
- From any state, a STOP goes to IDLE and a START goes to ADDR.
- ADDR goes to ADDR_ACK after eight bits that match the address, or to IDLE if they do not.
- ADDR_ACK goes to TX for a read or to PTR for a write.
- PTR goes to PTR_ACK, then to WDATA.
- WDATA goes to WDATA_ACK, which returns to WDATA.
- TX goes to TX_ACK after eight bits.
- TX_ACK goes back to TX when the controller acknowledged, or to IDLE when it did not.

Top module: `coil_i2c_target`

## Requirements
- R1: An address byte whose upper seven bits equal 0001110 is acknowledged, with bit 0 selecting write (0) or read (1). Any other address gets no acknowledge, and the rest of that transaction changes nothing.
- R2: SDA falling while SCL is high is a START, and it restarts address reception from any state, which allows a repeated START. SDA rising while SCL is high is a STOP, and it returns the block to idle. A byte cut short by a STOP writes nothing.
- R3: The acknowledge holds SDA low from the SCL falling edge that ends the 8th bit until the next SCL falling edge. Each edge is seen three clocks after the raw line changes.
- R4: In a write, the first byte after the address loads the pointer. Each later byte writes the register at the pointer, and the pointer then steps by one, wrapping from 0xFF to 0x00.
- R5: A read with no pointer byte starts at the current pointer. The pointer steps after each byte that the controller acknowledges and stays put after a byte it does not acknowledge. That non-acknowledge ends the transfer.
- R6: The register file sits at 0x02 control (reset 0x02), 0x03 current high bits 1:0 (reset 0), 0x04 current low byte (reset 0), 0x05 faults (read-only), 0x06 mode (reset 0) and 0x07 resonance frequency (reset 0x83). After reset the pointer is 0x00.
- R7: A write to 0x03 only stages the two high current bits. A write to 0x04 moves the staged high bits and the written byte onto the 10-bit current output together, and raises the commit strobe for exactly one clock.
- R8: Control bit 1 is the ring-compensation enable output. Writing control with bit 0 set returns every register and the current output to the reset values, and control then reads 0x02.
- R9: Mode bits 4:2 drive the PWM frequency select (000, 001, 011, 101, 110 and 111 are the meaningful codes, the others are reserved but stored). Bit 1 drives linear-mode select and bit 0 drives the single-period settling select. Bits 7:5 read as 0.
- R10: Writes to 0x05 or to unmapped addresses are acknowledged and have no effect. Reads of unmapped addresses return 0x00. 0x05 reads the 5-bit fault input in bits 4:0.
- R11: Register outputs and the commit strobe change after the third rising clock edge that samples SCL low at the end of the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| fault_i | input | 5 | Fault flags returned at register 0x05 |
| ring_en_o | output | 1 | Ring-compensation enable |
| coil_cur_o | output | 10 | Committed coil current code |
| coil_commit_o | output | 1 | One-clock pulse when a new current is committed |
| pwm_sel_o | output | 3 | PWM switching-frequency select |
| lin_mode_o | output | 1 | 1 selects the linear output stage |
| settle_one_o | output | 1 | 1 selects single-period settling |
| res_freq_o | output | 8 | Resonance-frequency code |

## Verification
A pointer that drifts from its true value does not stay hidden. It shows up on the next read as a byte from the neighbouring register, and on the next write as a change on the wrong output. The bench therefore keeps its own pointer and its own copy of the register contents. A state machine that slips a bit or loses its place in the frame shows within the same byte: the acknowledge is missing or sits one SCL phase off, and that is checked to the clock. A current value that is staged or committed wrongly shows on the coil outputs. Those outputs are compared on every clock, so an early, late or doubled commit is caught in the cycle it happens.

// File: rtl/coil_i2c_pkg.sv
package coil_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_state_t;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    localparam logic [7:0] RA_CTRL   = 8'h02;
    localparam logic [7:0] RA_CUR_HI = 8'h03;
    localparam logic [7:0] RA_CUR_LO = 8'h04;
    localparam logic [7:0] RA_FAULT  = 8'h05;
    localparam logic [7:0] RA_MODE   = 8'h06;
    localparam logic [7:0] RA_FREQ   = 8'h07;

    localparam logic [7:0] RST_FREQ  = 8'h83;

endpackage

// File: rtl/coil_i2c_sync.sv
module coil_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output coil_i2c_pkg::bus_ev_t ev_o
);
    localparam int LINES = 2;
    localparam int L_SCL = 1;
    localparam int L_SDA = 0;

    logic [STAGES-1:0][LINES-1:0] chain;
    logic [LINES-1:0]             settled;
    logic [LINES-1:0]             prev;

    assign settled = chain[STAGES-1];

    // Synchronizer chain and one-clock history; bus idles high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], {scl_i, sda_i}};
            prev  <= settled;
        end
    end

    always_comb begin
        ev_o.sda      = settled[L_SDA];
        ev_o.scl_rise = settled[L_SCL] & ~prev[L_SCL];
        ev_o.scl_fall = ~settled[L_SCL] & prev[L_SCL];
        ev_o.start    = settled[L_SCL] & prev[L_SCL] & prev[L_SDA] & ~settled[L_SDA];
        ev_o.stop     = settled[L_SCL] & prev[L_SCL] & ~prev[L_SDA] & settled[L_SDA];
    end

    // R2: a framing event is only reported while the clock line is steady high
    a_r2_frame_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_o.start || ev_o.stop) |-> !(ev_o.scl_rise || ev_o.scl_fall));

endmodule

// File: rtl/coil_i2c_fsm.sv
module coil_i2c_fsm #(
    parameter logic [6:0] DEV_ADDR = 7'b0001110
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  coil_i2c_pkg::bus_ev_t ev_i,
    input  logic [7:0]            rd_data_i,
    output logic [7:0]            rd_addr_o,
    output logic [7:0]            wr_addr_o,
    output logic [7:0]            wr_data_o,
    output logic                  wr_en_o,
    output logic                  sda_pull_o
);
    import coil_i2c_pkg::*;

    localparam logic [3:0] BYTE_BITS = 4'd8;
    localparam logic [3:0] LAST_TX   = 4'd7;

    bus_state_t state, state_nx;
    logic [7:0] shreg;
    logic [7:0] ptr;
    logic [3:0] bcnt;
    logic       mack;
    logic       byte_done;

    assign byte_done = ev_i.scl_fall && (bcnt == BYTE_BITS);

    // Next-state decision
    always_comb begin
        state_nx = state;
        if (ev_i.stop) begin
            state_nx = ST_IDLE;
        end else if (ev_i.start) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (byte_done) state_nx = (shreg[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (ev_i.scl_fall) state_nx = shreg[0] ? ST_TX : ST_PTR;
                ST_PTR:       if (byte_done) state_nx = ST_PTR_ACK;
                ST_PTR_ACK:   if (ev_i.scl_fall) state_nx = ST_WDATA;
                ST_WDATA:     if (byte_done) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (ev_i.scl_fall) state_nx = ST_WDATA;
                ST_TX:        if (ev_i.scl_fall && bcnt == LAST_TX) state_nx = ST_TX_ACK;
                ST_TX_ACK:    if (ev_i.scl_fall) state_nx = mack ? ST_TX : ST_IDLE;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Shift register, bit counter and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            ptr   <= '0;
            bcnt  <= '0;
            mack  <= 1'b0;
        end else if (ev_i.start || ev_i.stop) begin
            bcnt <= '0;
        end else begin
            case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (ev_i.scl_rise && bcnt != BYTE_BITS) begin
                        shreg <= {shreg[6:0], ev_i.sda};
                        bcnt  <= bcnt + 4'd1;
                    end
                    if (state == ST_PTR && byte_done)   ptr <= shreg;
                    if (state == ST_WDATA && byte_done) ptr <= ptr + 8'd1;
                end
                ST_ADDR_ACK: if (ev_i.scl_fall) begin
                    bcnt <= '0;
                    if (shreg[0]) shreg <= rd_data_i;
                end
                ST_PTR_ACK, ST_WDATA_ACK: if (ev_i.scl_fall) bcnt <= '0;
                ST_TX: if (ev_i.scl_fall) begin
                    shreg <= {shreg[6:0], 1'b0};
                    bcnt  <= bcnt + 4'd1;
                end
                ST_TX_ACK: begin
                    if (ev_i.scl_rise) mack <= ~ev_i.sda;
                    if (ev_i.scl_fall && mack) begin
                        shreg <= rd_data_i;
                        bcnt  <= '0;
                        ptr   <= ptr + 8'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sda_pull_o = 1'b0;
        wr_en_o    = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_pull_o = 1'b1;
            ST_TX:    sda_pull_o = ~shreg[7];
            ST_WDATA: wr_en_o    = byte_done && !ev_i.start && !ev_i.stop;
            default:  ;
        endcase
    end

    assign rd_addr_o = (state == ST_TX_ACK) ? ptr + 8'd1 : ptr;
    assign wr_addr_o = ptr;
    assign wr_data_o = shreg;

    // R4: every data write advances the pointer by exactly one
    a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> (ptr == $past(ptr) + 8'd1));

    // R3: an acknowledge phase only begins on a clock falling edge
    a_r3_ack_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ((state inside {ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK}) && !$stable(state))
        |-> $past(ev_i.scl_fall));

    // R5: a byte not acknowledged by the controller ends the read and keeps the pointer
    a_r5_nack_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_ACK && ev_i.scl_fall && !mack && !ev_i.start && !ev_i.stop)
        |=> (state == ST_IDLE && $stable(ptr)));

endmodule

// File: rtl/coil_regs.sv
module coil_regs #(
    parameter int CUR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [7:0]       wr_addr_i,
    input  logic [7:0]       wr_data_i,
    input  logic [7:0]       rd_addr_i,
    output logic [7:0]       rd_data_o,
    input  logic [4:0]       fault_i,
    output logic             ring_en_o,
    output logic [CUR_W-1:0] coil_cur_o,
    output logic             coil_commit_o,
    output logic [4:0]       mode_o,
    output logic [7:0]       res_freq_o
);
    import coil_i2c_pkg::*;

    localparam int HI_W = CUR_W - 8;

    logic             ring_q;
    logic [HI_W-1:0]  hi_q;
    logic [7:0]       lo_q;
    logic [4:0]       mode_q;
    logic [7:0]       freq_q;
    logic [CUR_W-1:0] cur_q;
    logic             commit_q;
    logic             soft_rst;

    assign soft_rst = wr_en_i && (wr_addr_i == RA_CTRL) && wr_data_i[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q   <= 1'b1;
            hi_q     <= '0;
            lo_q     <= '0;
            mode_q   <= '0;
            freq_q   <= RST_FREQ;
            cur_q    <= '0;
            commit_q <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            if (soft_rst) begin
                ring_q <= 1'b1;
                hi_q   <= '0;
                lo_q   <= '0;
                mode_q <= '0;
                freq_q <= RST_FREQ;
                cur_q  <= '0;
            end else if (wr_en_i) begin
                case (wr_addr_i)
                    RA_CTRL:   ring_q <= wr_data_i[1];
                    RA_CUR_HI: hi_q   <= wr_data_i[HI_W-1:0];
                    RA_CUR_LO: begin
                        lo_q     <= wr_data_i;
                        cur_q    <= {hi_q, wr_data_i};
                        commit_q <= 1'b1;
                    end
                    RA_MODE:   mode_q <= wr_data_i[4:0];
                    RA_FREQ:   freq_q <= wr_data_i;
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            RA_CTRL:   rd_data_o[1]        = ring_q;
            RA_CUR_HI: rd_data_o[HI_W-1:0] = hi_q;
            RA_CUR_LO: rd_data_o           = lo_q;
            RA_FAULT:  rd_data_o[4:0]      = fault_i;
            RA_MODE:   rd_data_o[4:0]      = mode_q;
            RA_FREQ:   rd_data_o           = freq_q;
            default:   ;
        endcase
    end

    assign ring_en_o     = ring_q;
    assign coil_cur_o    = cur_q;
    assign coil_commit_o = commit_q;
    assign mode_o        = mode_q;
    assign res_freq_o    = freq_q;

    // R7: the coil current moves only with a commit or a soft reset
    a_r7_cur_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q) |-> (commit_q || $past(soft_rst)));

    // R7: the commit strobe lasts one clock
    a_r7_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |=> !commit_q);

    // R8: a soft reset restores the defaults on the next clock
    a_r8_soft_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ring_q && mode_q == '0 && freq_q == RST_FREQ && cur_q == '0 && hi_q == '0));

endmodule

// File: rtl/coil_i2c_target.sv
module coil_i2c_target #(
    parameter logic [6:0] DEV_ADDR    = 7'b0001110,
    parameter int         SYNC_STAGES = 2,
    parameter int         CUR_W       = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o,
    input  logic [4:0]       fault_i,
    output logic             ring_en_o,
    output logic [CUR_W-1:0] coil_cur_o,
    output logic             coil_commit_o,
    output logic [2:0]       pwm_sel_o,
    output logic             lin_mode_o,
    output logic             settle_one_o,
    output logic [7:0]       res_freq_o
);
    import coil_i2c_pkg::*;

    bus_ev_t    ev;
    logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
    logic       wr_en;
    logic [4:0] mode;

    coil_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    coil_i2c_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev),
        .rd_data_i  (rd_data),
        .rd_addr_o  (rd_addr),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .wr_en_o    (wr_en),
        .sda_pull_o (sda_pull_o)
    );

    coil_regs #(.CUR_W(CUR_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en),
        .wr_addr_i     (wr_addr),
        .wr_data_i     (wr_data),
        .rd_addr_i     (rd_addr),
        .rd_data_o     (rd_data),
        .fault_i       (fault_i),
        .ring_en_o     (ring_en_o),
        .coil_cur_o    (coil_cur_o),
        .coil_commit_o (coil_commit_o),
        .mode_o        (mode),
        .res_freq_o    (res_freq_o)
    );

    assign pwm_sel_o    = mode[4:2];
    assign lin_mode_o   = mode[1];
    assign settle_one_o = mode[0];

endmodule

// File: tb/coil_i2c_target_test.sv
module coil_i2c_target_test;
    localparam int CLK_NS = 10;
    localparam int HALF   = 8;
    localparam logic [7:0] AW = 8'h1C;
    localparam logic [7:0] AR = 8'h1D;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
    logic [4:0] fault = 5'b10110;
    logic sda_pull, ring_en, commit, lin_mode, settle_one;
    logic [9:0] coil_cur;
    logic [2:0] pwm_sel;
    logic [7:0] res_freq;
    logic sda_line;
    assign sda_line = sda_m & ~sda_pull;

    coil_i2c_target uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull),
        .fault_i(fault), .ring_en_o(ring_en), .coil_cur_o(coil_cur), .coil_commit_o(commit),
        .pwm_sel_o(pwm_sel), .lin_mode_o(lin_mode), .settle_one_o(settle_one), .res_freq_o(res_freq)
    );

    always #(CLK_NS/2) clk = ~clk;

    int vecs = 0, errs = 0, cyc = 0;
    bit done = 0, cmp_on = 0;

    // behavioural model
    logic       m_ring = 1'b1;
    logic [1:0] m_hi = '0;
    logic [7:0] m_lo = '0, m_freq = 8'h83, m_ptr = '0;
    logic [4:0] m_mode = '0;
    logic [9:0] m_cur = '0;
    logic       m_commit = 1'b0;
    logic [7:0] pq_addr[$], pq_data[$];
    int         pq_due[$];

    function automatic void m_defaults();
        m_ring = 1'b1; m_hi = '0; m_lo = '0; m_mode = '0; m_freq = 8'h83; m_cur = '0;
    endfunction

    function automatic void m_write(logic [7:0] a, logic [7:0] d);
        case (a)
            8'h02: if (d[0]) m_defaults(); else m_ring = d[1];
            8'h03: m_hi = d[1:0];
            8'h04: begin m_lo = d; m_cur = {m_hi, d}; m_commit = 1'b1; end
            8'h06: m_mode = d[4:0];
            8'h07: m_freq = d;
            default: ;
        endcase
    endfunction

    function automatic logic [7:0] m_read(logic [7:0] a);
        case (a)
            8'h02: return {6'd0, m_ring, 1'b0};
            8'h03: return {6'd0, m_hi};
            8'h04: return m_lo;
            8'h05: return {3'd0, fault};
            8'h06: return {3'd0, m_mode};
            8'h07: return m_freq;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    endtask

    // per-clock comparison; writes land on the 4th sample after the byte-ending fall (R11)
    always @(negedge clk) begin
        #1;
        cyc++;
        m_commit = 1'b0;
        while (pq_due.size() > 0 && pq_due[0] == cyc) begin
            m_write(pq_addr.pop_front(), pq_data.pop_front());
            void'(pq_due.pop_front());
        end
        if (cmp_on) begin
            check(ring_en === m_ring, "R8 ring enable", ring_en, m_ring);
            check(coil_cur === m_cur && commit === m_commit, "R7/R11 current+commit",
                  {commit, coil_cur}, {m_commit, m_cur});
            check({pwm_sel, lin_mode, settle_one} === m_mode, "R9 mode fields",
                  {pwm_sel, lin_mode, settle_one}, m_mode);
            check(res_freq === m_freq, "R6 frequency", res_freq, m_freq);
        end
    end

    task automatic hw(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hw(HALF); scl = 1'b1; hw(HALF); sda_m = 1'b0; hw(HALF); scl = 1'b0; hw(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hw(HALF); scl = 1'b1; hw(HALF); sda_m = 1'b1; hw(HALF);
    endtask

    // sends a byte; arm queues a model write; tchk checks acknowledge timing (R3)
    task automatic send_byte(input logic [7:0] b, input bit arm, input logic [7:0] wa,
                             input bit tchk, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hw(HALF); scl = 1'b1; hw(HALF); scl = 1'b0;
            if (i == 0 && arm) begin
                pq_addr.push_back(wa); pq_data.push_back(b); pq_due.push_back(cyc + 4);
            end
        end
        sda_m = 1'b1;
        if (tchk) begin
            hw(2); check(sda_pull === 1'b0, "R3 ack not before edge", sda_pull, 0);
            hw(2); check(sda_pull === 1'b1, "R3 ack after edge", sda_pull, 1);
            hw(HALF - 4);
        end else hw(HALF);
        scl = 1'b1; hw(HALF/2); acked = (sda_line == 1'b0); hw(HALF - HALF/2); scl = 1'b0;
        if (tchk) begin
            hw(2); check(sda_pull === 1'b1, "R3 ack held to edge", sda_pull, 1);
            hw(2); check(sda_pull === 1'b0, "R3 ack released", sda_pull, 0);
        end
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit ack);
        sda_m = 1'b1; v = '0;
        for (int i = 7; i >= 0; i--) begin
            hw(HALF); scl = 1'b1; hw(HALF/2); v[i] = sda_line; hw(HALF - HALF/2); scl = 1'b0;
        end
        sda_m = ack ? 1'b0 : 1'b1; hw(HALF); scl = 1'b1; hw(HALF); scl = 1'b0; sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] p, input logic [7:0] d[$]);
        bit a;
        bus_start();
        send_byte(AW, 0, 0, 1, a); check(a, "R1 address ack", a, 1);
        send_byte(p, 0, 0, 1, a); check(a, "R4 pointer ack", a, 1);
        m_ptr = p;
        foreach (d[k]) begin
            send_byte(d[k], 1, m_ptr, 1, a); check(a, "R10 data ack", a, 1);
            m_ptr = m_ptr + 8'd1;
        end
        bus_stop();
    endtask

    task automatic read_body(input int n);
        logic [7:0] v;
        for (int k = 0; k < n; k++) begin
            recv_byte(v, k != n - 1);
            check(v === m_read(m_ptr), "R5 read data", v, m_read(m_ptr));
            if (k != n - 1) m_ptr = m_ptr + 8'd1;
        end
        bus_stop();
    endtask

    task automatic do_read_at(input logic [7:0] p, input int n);
        bit a;
        bus_start();
        send_byte(AW, 0, 0, 1, a); check(a, "R1 address ack", a, 1);
        send_byte(p, 0, 0, 1, a); check(a, "R4 pointer ack", a, 1);
        m_ptr = p;
        bus_start();
        send_byte(AR, 0, 0, 0, a); check(a, "R2 repeated start read ack", a, 1);
        read_body(n);
    endtask

    task automatic do_read_cur(input int n);
        bit a;
        bus_start();
        send_byte(AR, 0, 0, 0, a); check(a, "R5 current read ack", a, 1);
        read_body(n);
    endtask

    initial begin
        bit a;
        hw(5); rst_n = 1'b1; hw(2); cmp_on = 1;
        hw(4);
        // R6: reset values are covered by the per-clock compare; pointer starts at 0x00
        do_read_cur(1);                                  // R10 unmapped 0x00
        do_write(8'h07, '{8'h5A});                        // R6 frequency
        do_write(8'h03, '{8'hFF});                        // R7 staging only
        do_read_at(8'h03, 1);
        do_write(8'h04, '{8'h21, 8'hAA, 8'hFF});          // R7 commit, R10 fault ignored, R9 mode
        do_read_at(8'h01, 8);                             // R5 R10 R6 sequential read
        do_read_cur(2);                                   // R5 pointer kept after NACK
        // R1: wrong address, no ack, no effect
        bus_start();
        send_byte(8'h3C, 0, 0, 0, a); check(!a, "R1 foreign address no ack", a, 0);
        send_byte(8'h07, 0, 0, 0, a); check(!a, "R1 ignored pointer", a, 0);
        send_byte(8'h00, 0, 0, 0, a); check(!a, "R1 ignored data", a, 0);
        bus_stop();
        do_read_at(8'h07, 1);
        do_write(8'h02, '{8'h00});                        // R8 ring disable
        do_write(8'h06, '{8'h15});                        // R9 pwm 101, lin 0, settle 1
        do_write(8'h03, '{8'h02});
        do_write(8'h04, '{8'h00});                        // R7 commit 0x200
        do_write(8'h02, '{8'h01});                        // R8 soft reset
        do_read_at(8'h02, 3);                             // R8 control reads 0x02
        // R2: STOP inside a data byte writes nothing
        bus_start();
        send_byte(AW, 0, 0, 1, a); check(a, "R2 address ack", a, 1);
        send_byte(8'h07, 0, 0, 1, a); check(a, "R2 pointer ack", a, 1);
        m_ptr = 8'h07;
        for (int i = 7; i >= 4; i--) begin
            sda_m = 1'b1; hw(HALF); scl = 1'b1; hw(HALF); scl = 1'b0;
        end
        bus_stop();
        do_read_cur(1);                                   // R2 still 0x83
        do_write(8'hFF, '{8'h11, 8'h22, 8'h33, 8'h00});   // R4 wrap to 0x02
        do_read_cur(1);                                   // R4 pointer now 0x03
        hw(10);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule